// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the first six octets of each incoming frame, the destination address, and decides whether the frame is kept. Octets arrive one per cycle on a byte stream that has a valid strobe. A start marker travels with the first octet of every frame. The station's own address, a 64-bit group hash table and two mode bits set the filtering policy.

The block runs a CRC-32 over the six destination octets. Six bits of that CRC select one bit of the hash table, and that bit decides whether a group (multicast) frame is kept. After the sixth octet the block registers an accept decision, a broadcast flag and a multicast flag. These results stay constant until the next start marker. The receive path uses them to keep or drop the rest of the frame.

Top module: `da_filter`

## Requirements
- R1: While reset is asserted and after it is released, `decision_vld`, `accept`, `is_bcast` and `is_mcast` are all 0. Whenever `decision_vld` is 0, the other three outputs are 0.
- R2: An octet taken with `byte_vld` and `byte_sof` both high is octet 0 of a new address. At the clock edge that takes it, all four outputs clear. The edge that takes octet 5 sets `decision_vld` to 1 and loads the three result outputs.
- R3: A frame is accepted when all six octets equal `own_addr`. Octet k is compared with `own_addr[8k+7:8k]`, so `own_addr[7:0]` is the first octet received.
- R4: `is_mcast` is bit 0 of octet 0. `is_bcast` is 1 when all 48 address bits are 1. A broadcast frame is always accepted.
- R5: When `allmulti_en` is 1, every frame with `is_mcast` set is accepted.
- R6: For a multicast frame, the CRC register is preset to all ones. The 48 address bits are shifted in LSB first, octet 0 first, with generator 0x04C11DB7 in MSB-shifting form and no final inversion. The index is register bits 31..26, with bit 31 as the index MSB. The frame is accepted when `hash_table[index]` is 1.
- R7: When `promisc_en` is 1, every frame is accepted.
- R8: A frame that is not multicast and does not match `own_addr` is rejected, whatever `hash_table` and `allmulti_en` hold.
- R9: A cycle with `byte_vld` low takes no octet. Octets after the sixth, and any changes to the policy inputs after the decision, leave all four outputs unchanged until the next start marker.
- R10: A start marker during the address restarts the count, and only the octets from the latest marker count.
- R11: Octets that arrive after reset but before the first start marker are ignored, and `decision_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Octet on `byte_data` is valid this cycle |
| byte_sof | input | 1 | With `byte_vld`, marks octet 0 of a frame |
| byte_data | input | 8 | Received octet |
| own_addr | input | 48 | Station individual address; bits 7:0 are the first octet |
| hash_table | input | 64 | Group hash table, one bit per CRC index |
| allmulti_en | input | 1 | Accept every multicast frame |
| promisc_en | input | 1 | Accept every frame |
| decision_vld | output | 1 | Results below are valid |
| accept | output | 1 | Frame is to be kept |
| is_bcast | output | 1 | Destination is all ones |
| is_mcast | output | 1 | Destination group bit is set |

## Verification
The bound properties assume that `own_addr`, `hash_table` and the mode bits are settled in the cycle that carries the sixth octet. The properties on mode overrides look at the mode values one cycle back, at the edge where `decision_vld` rises. The stimulus holds the policy inputs steady for the whole address and changes them only while no octet is valid. Most addresses are drawn at random, with a bias toward the own address, the broadcast address and addresses with the group bit set. Directed cases cover gaps inside the address, restarts in the middle of the address, octets that trail the address, and octets that arrive before the first start marker.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;
   localparam int unsigned OCTET_W = 8;
   // Reflected form of generator 0x04C11DB7
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

   typedef struct packed {
      logic own_hit;
      logic all_ones;
      logic group;
   } da_flags_t;
endpackage

// File: rtl/da_byte_tracker.sv
module da_byte_tracker #(
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             byte_sof,
   output logic             start,
   output logic             take,
   output logic             first,
   output logic             last,
   output logic [CNT_W-1:0] idx
);
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      start = byte_vld & byte_sof;
      idx   = start ? '0 : cnt_q;
      take  = byte_vld & (start | (cnt_q < CNT_W'(ADDR_BYTES)));
      first = take & (idx == '0);
      last  = take & (idx == CNT_W'(ADDR_BYTES - 1));
   end

   // Reset parks the counter at "done" so nothing counts before a marker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(ADDR_BYTES);
      else if (take)
         cnt_q <= idx + CNT_W'(1);
   end
endmodule

// File: rtl/da_crc_unit.sv
module da_crc_unit
   import da_filter_pkg::*;
#(
   parameter int unsigned HASH_BITS = 6,
   parameter logic [31:0] POLY      = CRC_POLY_REFL,
   parameter logic [31:0] PRESET    = CRC_PRESET
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 take,
   input  logic [OCTET_W-1:0]   data,
   output logic [HASH_BITS-1:0] hash_nxt
);
   logic [31:0] crc_q;
   logic [31:0] stage [OCTET_W+1];

   assign stage[0] = start ? PRESET : crc_q;

   // One reflected shift per data bit, LSB of the octet first
   for (genvar g = 0; g < OCTET_W; g++) begin : g_bit
      logic fb;
      assign fb           = stage[g][0] ^ data[g];
      assign stage[g+1]   = (stage[g] >> 1) ^ (fb ? POLY : 32'h0);
   end

   // Reflected bit k holds normal-form bit 31-k
   for (genvar k = 0; k < HASH_BITS; k++) begin : g_hash
      assign hash_nxt[HASH_BITS-1-k] = stage[OCTET_W][k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= PRESET;
      else if (take)
         crc_q <= stage[OCTET_W];
   end
endmodule

// File: rtl/da_addr_match.sv
module da_addr_match
   import da_filter_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
   localparam int unsigned ADDR_W = OCTET_W * ADDR_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               take,
   input  logic               first,
   input  logic [CNT_W-1:0]   idx,
   input  logic [OCTET_W-1:0] data,
   input  logic [ADDR_W-1:0]  own_addr,
   output da_flags_t          flags_nxt
);
   logic [OCTET_W-1:0] own_oct [ADDR_BYTES];
   logic [OCTET_W-1:0] own_byte;
   da_flags_t          flags_q;
   da_flags_t          base;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_oct
      assign own_oct[g] = own_addr[OCTET_W*g +: OCTET_W];
   end

   always_comb begin
      own_byte = '0;
      for (int i = 0; i < ADDR_BYTES; i++)
         if (idx == CNT_W'(i)) own_byte = own_oct[i];
      if (start) begin
         base.own_hit  = 1'b1;
         base.all_ones = 1'b1;
         base.group    = 1'b0;
      end else begin
         base = flags_q;
      end
      flags_nxt.own_hit  = base.own_hit & (data == own_byte);
      flags_nxt.all_ones = base.all_ones & (&data);
      flags_nxt.group    = first ? data[0] : base.group;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else if (take)
         flags_q <= flags_nxt;
   end
endmodule

// File: rtl/da_filter.sv
module da_filter
   import da_filter_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_BITS  = 6,
   localparam int unsigned TABLE_W = 1 << HASH_BITS,
   localparam int unsigned ADDR_W  = OCTET_W * ADDR_BYTES,
   localparam int unsigned CNT_W   = $clog2(ADDR_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_vld,
   input  logic               byte_sof,
   input  logic [OCTET_W-1:0] byte_data,
   input  logic [ADDR_W-1:0]  own_addr,
   input  logic [TABLE_W-1:0] hash_table,
   input  logic               allmulti_en,
   input  logic               promisc_en,
   output logic               decision_vld,
   output logic               accept,
   output logic               is_bcast,
   output logic               is_mcast
);
   if (ADDR_BYTES < 1 || ADDR_BYTES > 16) begin : g_bad_addr
      $error("da_filter: ADDR_BYTES out of range");
   end
   if (HASH_BITS < 1 || HASH_BITS > 12) begin : g_bad_hash
      $error("da_filter: HASH_BITS out of range");
   end

   logic             start, take, first, last;
   logic [CNT_W-1:0] idx;
   logic [HASH_BITS-1:0] hash_nxt;
   da_flags_t        flags_nxt;
   logic             acc_nxt;

   da_byte_tracker #(.ADDR_BYTES(ADDR_BYTES)) i_tracker (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
      .start(start), .take(take), .first(first), .last(last), .idx(idx)
   );

   da_crc_unit #(.HASH_BITS(HASH_BITS)) i_crc (
      .clk(clk), .rst_n(rst_n), .start(start), .take(take),
      .data(byte_data), .hash_nxt(hash_nxt)
   );

   da_addr_match #(.ADDR_BYTES(ADDR_BYTES)) i_match (
      .clk(clk), .rst_n(rst_n), .start(start), .take(take), .first(first),
      .idx(idx), .data(byte_data), .own_addr(own_addr), .flags_nxt(flags_nxt)
   );

   always_comb begin
      acc_nxt = promisc_en | flags_nxt.own_hit | flags_nxt.all_ones |
                (flags_nxt.group & (allmulti_en | hash_table[hash_nxt]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         decision_vld <= 1'b0;
         accept       <= 1'b0;
         is_bcast     <= 1'b0;
         is_mcast     <= 1'b0;
      end else if (last) begin
         decision_vld <= 1'b1;
         accept       <= acc_nxt;
         is_bcast     <= flags_nxt.all_ones;
         is_mcast     <= flags_nxt.group;
      end else if (start) begin
         decision_vld <= 1'b0;
         accept       <= 1'b0;
         is_bcast     <= 1'b0;
         is_mcast     <= 1'b0;
      end
   end
endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk #(
   parameter int unsigned ADDR_BYTES = 6
) (
   input logic clk,
   input logic rst_n,
   input logic byte_vld,
   input logic byte_sof,
   input logic allmulti_en,
   input logic promisc_en,
   input logic decision_vld,
   input logic accept,
   input logic is_bcast,
   input logic is_mcast
);
   AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !decision_vld |-> !accept && !is_bcast && !is_mcast); // R1

   AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ADDR_BYTES > 1) && byte_vld && byte_sof |=> !decision_vld); // R2

   AST_BCAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      decision_vld && is_bcast |-> is_mcast && accept); // R4

   AST_ALLMULTI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decision_vld) && $past(allmulti_en) && is_mcast |-> accept); // R5

   AST_PROMISC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decision_vld) && $past(promisc_en) |-> accept); // R7

   AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      decision_vld && !(byte_vld && byte_sof) |=>
      decision_vld && $stable(accept) && $stable(is_bcast) && $stable(is_mcast)); // R9
endmodule

bind da_filter da_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) i_da_filter_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
   .allmulti_en(allmulti_en), .promisc_en(promisc_en),
   .decision_vld(decision_vld), .accept(accept),
   .is_bcast(is_bcast), .is_mcast(is_mcast)
);

// File: tb/test_da_filter.sv
`timescale 1ns/1ps
module test_da_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic        byte_sof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [47:0] own_addr = 48'h0;
   logic [63:0] hash_table = '0;
   logic        allmulti_en = 1'b0;
   logic        promisc_en = 1'b0;
   logic        decision_vld, accept, is_bcast, is_mcast;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   da_filter i_da_filter (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
      .byte_data(byte_data), .own_addr(own_addr), .hash_table(hash_table),
      .allmulti_en(allmulti_en), .promisc_en(promisc_en),
      .decision_vld(decision_vld), .accept(accept),
      .is_bcast(is_bcast), .is_mcast(is_mcast)
   );

   function automatic logic [5:0] ref_index(input logic [47:0] da);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[31] ^ da[i];
         c = {c[30:0], 1'b0};
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] da);
      logic grp = da[0];
      return promisc_en || (da == own_addr) || (&da) ||
             (grp && (allmulti_en || hash_table[ref_index(da)]));
   endfunction

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] d, input logic sof);
      @(negedge clk);
      byte_vld  = 1'b1;
      byte_sof  = sof;
      byte_data = d;
   endtask

   task automatic idle();
      @(negedge clk);
      byte_vld = 1'b0;
      byte_sof = 1'b0;
      byte_data = 8'($urandom);
   endtask

   // Sends six octets, octet 0 first; optional idle gap before octet 3
   task automatic send_addr(input logic [47:0] da, input bit gap);
      for (int i = 0; i < 6; i++) begin
         if (gap && i == 3) idle();
         put_byte(da[8*i +: 8], i == 0);
      end
      idle();
   endtask

   task automatic check_result(input string req, input logic [47:0] da);
      chk({req, " vld"},   decision_vld, 1'b1);
      chk({req, " accept"}, accept, ref_accept(da));
      chk({req, " bcast"}, is_bcast, &da);
      chk({req, " mcast"}, is_mcast, da[0]);
   endtask

   initial begin
      logic [47:0] da;
      logic [5:0]  ix;
      void'($urandom(32'd24680));
      own_addr = 48'h5634_12EF_CD02;
      repeat (3) @(negedge clk);
      chk("R1 vld in reset", decision_vld, 1'b0);
      chk("R1 accept in reset", accept, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld after reset", decision_vld, 1'b0);

      // R11: octets before any start marker are ignored
      for (int i = 0; i < 6; i++) put_byte(own_addr[8*i +: 8], 1'b0);
      idle();
      chk("R11 no decision", decision_vld, 1'b0);
      chk("R11 no accept", accept, 1'b0);

      // R3 own address, with a gap inside (R9)
      send_addr(own_addr, 1'b1);
      check_result("R3 own", own_addr);
      chk("R3 own accepted", accept, 1'b1);

      // R9 trailing octets and policy changes do not move the result
      promisc_en = 1'b1;
      for (int i = 0; i < 5; i++) put_byte(8'hFF, 1'b0);
      idle();
      chk("R9 held vld", decision_vld, 1'b1);
      chk("R9 held accept", accept, 1'b1);
      chk("R9 held mcast", is_mcast, 1'b0);
      promisc_en = 1'b0;

      // R2 start marker clears outputs at the edge that takes it
      put_byte(8'h01, 1'b1);
      idle();
      chk("R2 cleared vld", decision_vld, 1'b0);
      chk("R2 cleared accept", accept, 1'b0);

      // R4 broadcast with all modes off
      send_addr('1, 1'b0);
      check_result("R4 bcast", '1);
      chk("R4 bcast accepted", accept, 1'b1);

      // R6 hash: only the selected bit set, then only it cleared
      da = 48'h0000_2A00_5E01;
      ix = ref_index(da);
      hash_table = 64'd1 << ix;
      send_addr(da, 1'b0);
      chk("R6 hash hit", accept, 1'b1);
      hash_table = ~(64'd1 << ix);
      send_addr(da, 1'b0);
      chk("R6 hash miss", accept, 1'b0);
      chk("R6 mcast flag", is_mcast, 1'b1);

      // R5 accept-all-multicast
      allmulti_en = 1'b1;
      send_addr(da, 1'b0);
      chk("R5 allmulti", accept, 1'b1);

      // R8 unicast non-own rejected despite full table and allmulti
      hash_table = '1;
      send_addr(48'h0000_0000_0010, 1'b0);
      chk("R8 unicast reject", accept, 1'b0);
      allmulti_en = 1'b0;

      // R7 promiscuous
      promisc_en = 1'b1;
      send_addr(48'h1111_2222_3344, 1'b0);
      chk("R7 promisc", accept, 1'b1);
      promisc_en = 1'b0;
      hash_table = '0;

      // R10 restart in the middle of an address
      put_byte(8'hAA, 1'b1);
      put_byte(8'hBB, 1'b0);
      put_byte(8'hCC, 1'b0);
      send_addr(own_addr, 1'b0);
      check_result("R10 restart", own_addr);
      chk("R10 restart accept", accept, 1'b1);

      // Random frames
      for (int n = 0; n < 400; n++) begin
         int sel = $urandom % 8;
         hash_table  = {$urandom, $urandom};
         allmulti_en = ($urandom % 4) == 0;
         promisc_en  = ($urandom % 6) == 0;
         da = {$urandom, $urandom};
         if (sel < 2) da = own_addr;
         else if (sel == 2) da = '1;
         else if (sel < 5) da[0] = 1'b1;
         else da[0] = 1'b0;
         send_addr(da, ($urandom % 3) == 0);
         check_result("R6 random", da);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule